// File: doc/BRIEF.md
# Filter-Chain Instruction Sequencer

This block is a small microprogrammed controller. It decides the order and the number of cascaded filters that run on one shared FIR compute engine. A program of up to 32 instruction words sits in a local store, which is loaded through a write port. The sequencer walks that program with a program counter. When it reaches a filter instruction, it raises a dispatch request toward the engine and presents the decoded filter fields with it. It then holds until the engine reports completion.

Program-flow instructions take one clock each. A wait instruction holds the program until enough input samples have arrived. The count is compared against a threshold register, which normally holds the total decimation of the chain. A filter instruction can carry a flag that removes its decimation from the sample count when it retires. Loop-counter loads and jumps, conditional and unconditional, let a program repeat filters and cycle forever. The minimal program is a wait, one filter, and a jump back to step 0.

Each instruction word is 16 bits:
- bits [15:13] hold the opcode;
- for a filter, bit 12 is the consume flag, bits [11:8] the decimation and bits [7:0] a configuration byte passed to the engine;
- jumps take their target from bits [4:0];
- a loop load takes its immediate from bits [7:0].

Top module: `fchain_seq`

## Requirements
- R1: After reset the program counter is 0, the sample count and loop counter are 0, and every store word holds a wait instruction (opcode 1), so no dispatch is requested.
- R2: Opcode 0 (filter) drives disp_req high with disp_cfg = bits [7:0], disp_decim = bits [11:8], disp_dec_wait = bit 12 and disp_step = program counter. The counter holds while disp_done is low and advances by one in the cycle disp_done is high. While disp_req is low, the three field outputs are 0.
- R3: Opcode 1 (wait) advances the counter after one cycle when the sample count is at or above wait_thresh; otherwise it stalls at the same step.
- R4: Every cycle with sample_stb high adds one to the sample count, including during waits and dispatches. The count is 8 bits wide and saturates at 255 instead of wrapping.
- R5: A filter that retires with bit 12 set subtracts its decimation from the sample count in the same cycle as any increment. The result does not go below 0.
- R6: Opcode 2 loads the loop counter with bits [7:0] and advances in one cycle.
- R7: Opcode 3 jumps to the step in bits [4:0] in one cycle.
- R8: Opcode 4 jumps to bits [4:0] and decrements the loop counter when the counter is nonzero. When it is zero, it falls through to the next step and leaves the counter at 0.
- R9: Opcodes 5, 6 and 7 advance by one step in one cycle and have no other effect.
- R10: Advancing from step 31 leads to step 0.
- R11: A store write takes effect at the next clock edge; the instruction executed at that edge is the previously stored one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_we | input | 1 | Program store write enable |
| imem_waddr | input | 5 | Program store write address |
| imem_wdata | input | 16 | Program store write data |
| sample_stb | input | 1 | One input sample arrived |
| wait_thresh | input | 8 | Sample count needed by a wait instruction |
| disp_req | output | 1 | Filter dispatch request to the engine |
| disp_step | output | 5 | Current program step |
| disp_cfg | output | 8 | Filter configuration byte |
| disp_decim | output | 4 | Filter decimation |
| disp_dec_wait | output | 1 | Filter consumes samples on retire |
| disp_done | input | 1 | Engine finished the dispatched filter |

## Verification
The sample count can receive an arriving strobe and a retiring consume-flagged filter in the same cycle. It can also receive a strobe during a stall at a wait, where the increment decides whether the stall ends one cycle later. These collisions are provoked by running strobe trains at fixed spacing against engine latencies that slide relative to them. A single strobe is followed by a decimation larger than the count, which forces the floor at zero. A long continuous train pushes the count past saturation. Each case is judged by comparing dispatch outputs every cycle against a behavioural interpreter of the program. A wrong count shows up as a wait that releases or stalls at the wrong moment.

// File: rtl/fchain_seq_pkg.sv
package fchain_seq_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_FILT = 3'd0,
    OP_WAIT = 3'd1,
    OP_LOOP = 3'd2,
    OP_JMP  = 3'd3,
    OP_JNZ  = 3'd4
  } op_e;

  // next sample count: add the strobe, remove consumed samples, clamp to [0, maxv]
  function automatic int unsigned wait_next(int unsigned cnt, logic inc,
                                            int unsigned dec, int unsigned maxv);
    int v;
    v = int'(cnt) + (inc ? 1 : 0) - int'(dec);
    if (v < 0) v = 0;
    if (v > int'(maxv)) v = int'(maxv);
    return int'(v);
  endfunction
endpackage

// File: rtl/fchain_imem.sv
module fchain_imem #(
  parameter int AW = 5,
  parameter int IW = 16,
  parameter logic [IW-1:0] RST_WORD = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [IW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [IW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [IW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= RST_WORD;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/fchain_wait_ctr.sv
module fchain_wait_ctr #(
  parameter int CNT_W = 8,
  parameter int DEC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec_en,
  input  logic [DEC_W-1:0] dec_amt,
  output logic [CNT_W-1:0] cnt
);
  import fchain_seq_pkg::*;

  localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = CNT_W'(wait_next(int'(cnt_q), inc,
                             dec_en ? int'(dec_amt) : 0, CNT_MAX));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/fchain_ctrl.sv
module fchain_ctrl #(
  parameter int PC_W   = 5,
  parameter int CNT_W  = 8,
  parameter int LOOP_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [fchain_seq_pkg::OP_W-1:0] op_bits,
  input  logic [PC_W-1:0]               tgt,
  input  logic [LOOP_W-1:0]             imm,
  input  logic [CNT_W-1:0]              cnt,
  input  logic [CNT_W-1:0]              thresh,
  input  logic                          done,
  output logic [PC_W-1:0]               pc,
  output logic [LOOP_W-1:0]             loop_cnt,
  output logic                          is_filt,
  output logic                          filt_retire,
  output logic                          wait_stall,
  output logic                          jump_taken,
  output logic                          load_ev
);
  import fchain_seq_pkg::*;

  op_e              op;
  logic [PC_W-1:0]  pc_q, pc_d;
  logic [LOOP_W-1:0] loop_q, loop_d;

  assign op = op_e'(op_bits);

  always_comb begin
    pc_d        = pc_q + 1'b1;
    loop_d      = loop_q;
    is_filt     = 1'b0;
    filt_retire = 1'b0;
    wait_stall  = 1'b0;
    jump_taken  = 1'b0;
    load_ev     = 1'b0;
    case (op)
      OP_FILT: begin
        is_filt     = 1'b1;
        filt_retire = done;
        if (!done) pc_d = pc_q;
      end
      OP_WAIT: begin
        if (cnt < thresh) begin
          wait_stall = 1'b1;
          pc_d       = pc_q;
        end
      end
      OP_LOOP: begin
        load_ev = 1'b1;
        loop_d  = imm;
      end
      OP_JMP: begin
        jump_taken = 1'b1;
        pc_d       = tgt;
      end
      OP_JNZ: begin
        if (loop_q != '0) begin
          jump_taken = 1'b1;
          loop_d     = loop_q - 1'b1;
          pc_d       = tgt;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      loop_q <= '0;
    end else begin
      pc_q   <= pc_d;
      loop_q <= loop_d;
    end
  end

  assign pc       = pc_q;
  assign loop_cnt = loop_q;
endmodule

// File: rtl/fchain_seq.sv
module fchain_seq #(
  parameter int PC_W   = 5,
  parameter int CNT_W  = 8,
  parameter int LOOP_W = 8,
  parameter int CFG_W  = 8,
  parameter int DEC_W  = 4
) (
  input  logic                                           clk,
  input  logic                                           rst_n,
  input  logic                                           imem_we,
  input  logic [PC_W-1:0]                                imem_waddr,
  input  logic [fchain_seq_pkg::OP_W+1+DEC_W+CFG_W-1:0] imem_wdata,
  input  logic                                           sample_stb,
  input  logic [CNT_W-1:0]                               wait_thresh,
  output logic                                           disp_req,
  output logic [PC_W-1:0]                                disp_step,
  output logic [CFG_W-1:0]                               disp_cfg,
  output logic [DEC_W-1:0]                               disp_decim,
  output logic                                           disp_dec_wait,
  input  logic                                           disp_done
);
  import fchain_seq_pkg::*;

  localparam int IW       = OP_W + 1 + DEC_W + CFG_W;
  localparam int FLAG_BIT = CFG_W + DEC_W;
  localparam logic [IW-1:0] WAIT_WORD = {OP_WAIT, {(IW-OP_W){1'b0}}};

  logic [IW-1:0]     instr;
  logic [PC_W-1:0]   pc_q;
  logic [LOOP_W-1:0] loop_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              is_filt, filt_retire, wait_stall, jump_taken, load_ev;
  logic              dec_en;
  logic [DEC_W-1:0]  dec_amt;
  logic [PC_W-1:0]   jump_tgt;
  logic [LOOP_W-1:0] load_imm;

  assign dec_amt  = instr[CFG_W +: DEC_W];
  assign dec_en   = filt_retire & instr[FLAG_BIT];
  assign jump_tgt = instr[PC_W-1:0];
  assign load_imm = instr[LOOP_W-1:0];

  fchain_imem #(.AW(PC_W), .IW(IW), .RST_WORD(WAIT_WORD)) imem_i (
    .clk(clk), .rst_n(rst_n), .we(imem_we), .waddr(imem_waddr),
    .wdata(imem_wdata), .raddr(pc_q), .rdata(instr)
  );

  fchain_wait_ctr #(.CNT_W(CNT_W), .DEC_W(DEC_W)) wctr_i (
    .clk(clk), .rst_n(rst_n), .inc(sample_stb), .dec_en(dec_en),
    .dec_amt(dec_amt), .cnt(cnt_q)
  );

  fchain_ctrl #(.PC_W(PC_W), .CNT_W(CNT_W), .LOOP_W(LOOP_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .op_bits(instr[IW-1 -: OP_W]),
    .tgt(jump_tgt), .imm(load_imm), .cnt(cnt_q), .thresh(wait_thresh),
    .done(disp_done), .pc(pc_q), .loop_cnt(loop_q), .is_filt(is_filt),
    .filt_retire(filt_retire), .wait_stall(wait_stall),
    .jump_taken(jump_taken), .load_ev(load_ev)
  );

  assign disp_req      = is_filt;
  assign disp_step     = pc_q;
  assign disp_cfg      = is_filt ? instr[CFG_W-1:0] : '0;
  assign disp_decim    = is_filt ? dec_amt : '0;
  assign disp_dec_wait = is_filt & instr[FLAG_BIT];
endmodule

// File: rtl/fchain_seq_chk.sv
module fchain_seq_chk #(
  parameter int PC_W   = 5,
  parameter int CNT_W  = 8,
  parameter int LOOP_W = 8,
  parameter int DEC_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PC_W-1:0]   pc,
  input logic [LOOP_W-1:0] loop_cnt,
  input logic [CNT_W-1:0]  cnt,
  input logic              disp_req,
  input logic              disp_done,
  input logic              sample_stb,
  input logic              dec_en,
  input logic [DEC_W-1:0]  dec_amt,
  input logic              wait_stall,
  input logic              jump_taken,
  input logic [PC_W-1:0]   jump_tgt,
  input logic              load_ev,
  input logic [LOOP_W-1:0] load_imm
);
  // R2
  disp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_req && !disp_done |=> pc == $past(pc));

  // R3
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_stall |=> pc == $past(pc));

  // R4
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '1) && sample_stb && !dec_en |=> cnt == '1);

  // R4
  cnt_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '1) && sample_stb && !dec_en |=> cnt == $past(cnt) + 1'b1);

  // R5
  cnt_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en && !sample_stb && (cnt < dec_amt) |=> cnt == '0);

  // R6
  loop_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> loop_cnt == $past(load_imm));

  // R7
  jump_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jump_taken |=> pc == $past(jump_tgt));
endmodule

bind fchain_seq fchain_seq_chk #(
  .PC_W(PC_W), .CNT_W(CNT_W), .LOOP_W(LOOP_W), .DEC_W(DEC_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .pc(pc_q), .loop_cnt(loop_q), .cnt(cnt_q),
  .disp_req(disp_req), .disp_done(disp_done), .sample_stb(sample_stb),
  .dec_en(dec_en), .dec_amt(dec_amt), .wait_stall(wait_stall),
  .jump_taken(jump_taken), .jump_tgt(jump_tgt), .load_ev(load_ev),
  .load_imm(load_imm)
);

// File: tb/fchain_seq_tb.sv
module fchain_seq_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        imem_we = 0;
  logic [4:0]  imem_waddr = 0;
  logic [15:0] imem_wdata = 0;
  logic        sample_stb = 0;
  logic [7:0]  wait_thresh = 8'd255;
  logic        disp_req;
  logic [4:0]  disp_step;
  logic [7:0]  disp_cfg;
  logic [3:0]  disp_decim;
  logic        disp_dec_wait;
  logic        disp_done = 0;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int stb_left = 0;
  int stb_period = 1;
  int eng_lat = 0;
  int hold = 0;
  string phase = "R1";

  int m_mem [32];
  int m_pc, m_cnt, m_loop, last_op;

  fchain_seq dut_i (
    .clk(clk), .rst_n(rst_n), .imem_we(imem_we), .imem_waddr(imem_waddr),
    .imem_wdata(imem_wdata), .sample_stb(sample_stb), .wait_thresh(wait_thresh),
    .disp_req(disp_req), .disp_step(disp_step), .disp_cfg(disp_cfg),
    .disp_decim(disp_decim), .disp_dec_wait(disp_dec_wait), .disp_done(disp_done)
  );

  always #10 clk = ~clk;

  function automatic int w_filt(int fl, int dc, int cfg);
    return (fl << 12) | (dc << 8) | cfg;
  endfunction
  function automatic int w_op(int op, int low);
    return (op << 13) | low;
  endfunction

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // behavioural interpreter of the program
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) m_mem[i] = w_op(1, 0);
      m_pc = 0; m_cnt = 0; m_loop = 0; last_op = -1;
    end else begin
      int w, op, np, nl, nc;
      w  = m_mem[m_pc];
      op = (w >> 13) & 7;
      np = (m_pc + 1) % 32;
      nl = m_loop;
      nc = m_cnt + (sample_stb ? 1 : 0);
      if (op == 0 && disp_done && ((w >> 12) & 1) == 1) nc = nc - ((w >> 8) & 15);
      if (nc < 0) nc = 0;
      if (nc > 255) nc = 255;
      case (op)
        0: if (!disp_done) np = m_pc;
        1: if (m_cnt < int'(wait_thresh)) np = m_pc;
        2: nl = w & 255;
        3: np = w & 31;
        4: if (m_loop != 0) begin nl = m_loop - 1; np = w & 31; end
        default: ;
      endcase
      if (imem_we) m_mem[imem_waddr] = int'(imem_wdata);
      m_pc = np; m_loop = nl; m_cnt = nc; last_op = op;
    end
  end

  // per-cycle comparison against the interpreter
  always @(negedge clk) begin
    if (rst_n && last_op >= 0) begin
      int w, req;
      string t;
      logic [18:0] got, exp;
      w   = m_mem[m_pc];
      req = (((w >> 13) & 7) == 0) ? 1 : 0;
      got = {disp_req, disp_step, disp_cfg, disp_decim, disp_dec_wait};
      exp = {req[0], m_pc[4:0], req != 0 ? w[7:0] : 8'd0,
             req != 0 ? w[11:8] : 4'd0, req != 0 ? w[12] : 1'b0};
      case (last_op)
        0: t = "R2"; 1: t = "R3"; 2: t = "R6"; 3: t = "R7"; 4: t = "R8";
        default: t = "R9";
      endcase
      total++;
      if (got !== exp) begin
        bad++;
        $display("FAIL %s/%s cyc=%0d: got=%h expected=%h", phase, t, cyc, got, exp);
      end
    end
  end

  // compute engine stand-in
  always @(negedge clk) begin
    if (!rst_n) begin
      disp_done = 0; hold = 0;
    end else if (disp_done) begin
      disp_done = 0; hold = 0;
    end else if (disp_req) begin
      if (hold >= eng_lat) disp_done = 1;
      else hold++;
    end else hold = 0;
  end

  // sample strobe source
  always @(negedge clk) begin
    if (stb_left > 0 && (cyc % stb_period) == 0) begin
      sample_stb = 1; stb_left--;
    end else sample_stb = 0;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: got=expired expected=finished");
      finish_run();
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; wait_thresh = 8'd255; stb_left = 0;
    run(3);
    rst_n = 1;
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    imem_we = 1; imem_waddr = a[4:0]; imem_wdata = d[15:0];
    @(negedge clk);
    imem_we = 0;
  endtask

  initial begin
    // R1: reset state
    phase = "R1";
    do_reset();
    #1;
    total++;
    if (disp_req !== 1'b0 || disp_step !== 5'd0) begin
      bad++;
      $display("FAIL R1: got req=%b step=%0d expected req=0 step=0", disp_req, disp_step);
    end
    run(5);

    // R2 R3 R5: wait, consume filter, plain filter, jump
    phase = "R2_R3_R5";
    wr(1, w_filt(1, 2, 8'h11));
    wr(2, w_filt(0, 1, 8'h22));
    wr(3, w_op(3, 0));
    wait_thresh = 2; eng_lat = 2; stb_period = 3; stb_left = 1000;
    run(300);
    eng_lat = 0; stb_period = 1;
    run(200);

    // R6 R7 R8 R9: loop program
    phase = "R6_R7_R8_R9";
    do_reset();
    wr(0, w_op(2, 3));
    wr(1, w_filt(0, 1, 8'h33));
    wr(2, w_op(4, 1));
    wr(3, w_op(5, 0));
    wr(4, w_op(2, 0));
    wr(5, w_op(4, 0));
    wr(6, w_op(7, 0));
    wr(7, w_op(3, 0));
    wait_thresh = 0; eng_lat = 1;
    run(200);

    // R4: saturation against a full threshold
    phase = "R4";
    do_reset();
    wr(1, w_filt(0, 3, 8'h44));
    wr(2, w_op(3, 0));
    eng_lat = 0; stb_period = 1; stb_left = 300;
    run(400);

    // R5: floor at zero, then strobes colliding with decrements
    phase = "R5";
    do_reset();
    wr(1, w_filt(1, 15, 8'h66));
    wr(2, w_op(3, 0));
    wait_thresh = 1; eng_lat = 3; stb_period = 1; stb_left = 1;
    run(50);
    stb_left = 40; stb_period = 2;
    run(150);

    // R9 R10: no-op run to the last step and wrap
    phase = "R9_R10";
    do_reset();
    for (int i = 1; i < 31; i++) wr(i, w_op(5 + (i % 3), 0));
    wr(31, w_filt(0, 2, 8'h77));
    wait_thresh = 0; eng_lat = 0;
    run(200);

    // R11: write into the running program
    phase = "R11";
    do_reset();
    wr(1, w_op(3, 0));
    wait_thresh = 0;
    run(20);
    wr(1, w_filt(1, 1, 8'h55));
    run(30);
    wr(0, w_op(3, 1));
    run(30);

    finish_run();
  end
endmodule